// File: doc/BRIEF.md
# Iterative Integer Multiplier

This block multiplies two 64-bit register values one bit per clock and hands back a single 64-bit answer. A single datapath covers eight variants. They differ in three ways: whether the operands are taken as 32-bit or 64-bit values, whether those values are signed or unsigned, and which slice of the full product is returned. The word variants can also widen the product or sign-extend a 32-bit slice back to 64 bits.

A pipeline issues an operation by raising `start` for one cycle. On that cycle it presents the 17-bit function field, taken from instruction bits 31:15, together with both operands. The block is busy while it iterates. It then pulses `done` for one cycle, with the result already valid on `result`. Signed variants multiply operand magnitudes and negate the finished product when the operand signs differ.

Top module: `mulx_unit`

## Requirements
- R1: Code 0x38 (low word) multiplies the signed low 32 bits of both operands and returns bits 31:0 of the product sign-extended from bit 31; operand bits 63:32 have no effect.
- R2: Codes 0x39 (signed) and 0x3A (unsigned) form the 64-bit product of the low 32-bit operands and return its bits 63:32 sign-extended from product bit 63, for both signednesses.
- R3: Code 0x3B returns the low 64 bits of the product of the full operands.
- R4: Codes 0x3C (signed) and 0x3D (unsigned) return bits 127:64 of the 128-bit product of the full operands.
- R5: Codes 0x3E (signed) and 0x3F (unsigned) return the complete 64-bit product of the extended low 32-bit operands.
- R6: A start is accepted only when func_code bits 16:3 equal 0x7; any other code leaves the block idle, produces no done pulse and leaves result unchanged.
- R7: After an accepted start, busy is high from the next cycle; done rises 33 cycles after the start edge for the word codes (0x38, 0x39, 0x3A, 0x3E, 0x3F) and 65 cycles after it for 0x3B to 0x3D; busy is low while done is high.
- R8: A start raised while busy is ignored: the running operation completes with its own operands and no extra done pulse follows.
- R9: done is high for exactly one cycle, and result changes only on the cycle done is high, holding otherwise.
- R10: While reset is low, busy and done are low and result is zero; a reset during an operation abandons it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Issue strobe, one cycle |
| func_code | input | 17 | Operation code, instruction bits 31:15 |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Result, held between completions |

## Verification
Every code is run with pairs that set the sign bits at bit 31 and at bit 63. This separates sign extension from zero extension of the operands, and catches a word variant that wrongly reads the upper operand bits. The most negative values multiplied by each other or by minus one test the magnitude and negation path, where the magnitude equals the sign bit alone. The all-ones unsigned cases separate arithmetic from logical extension of the returned high word. Restarts during a busy phase and codes just outside the accepted range confirm that nothing disturbs a running or idle block. Latency is counted per code to tell the 32-step path from the 64-step path.

// File: rtl/mulx_pkg.sv
package mulx_pkg;

    typedef enum logic [1:0] {
        RSEL_LO_W  = 2'd0,
        RSEL_MID_W = 2'd1,
        RSEL_LO_D  = 2'd2,
        RSEL_HI_D  = 2'd3
    } rsel_e;

    typedef struct packed {
        logic  word;
        logic  sgn;
        rsel_e rsel;
    } mctl_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_FIN  = 2'd2
    } st_e;

    // Low three code bits select the variant; order matters for decode.
    function automatic mctl_t decode_op(input logic [2:0] idx);
        mctl_t c;
        case (idx)
            3'd0:    c = '{word: 1'b1, sgn: 1'b1, rsel: RSEL_LO_W};
            3'd1:    c = '{word: 1'b1, sgn: 1'b1, rsel: RSEL_MID_W};
            3'd2:    c = '{word: 1'b1, sgn: 1'b0, rsel: RSEL_MID_W};
            3'd3:    c = '{word: 1'b0, sgn: 1'b0, rsel: RSEL_LO_D};
            3'd4:    c = '{word: 1'b0, sgn: 1'b1, rsel: RSEL_HI_D};
            3'd5:    c = '{word: 1'b0, sgn: 1'b0, rsel: RSEL_HI_D};
            3'd6:    c = '{word: 1'b1, sgn: 1'b1, rsel: RSEL_LO_D};
            default: c = '{word: 1'b1, sgn: 1'b0, rsel: RSEL_LO_D};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/mulx_opprep.sv
module mulx_opprep #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  opa,
    input  logic [XLEN-1:0]  opb,
    input  mulx_pkg::mctl_t  ctl,
    output logic [XLEN-1:0]  mag_a,
    output logic [XLEN-1:0]  mag_b,
    output logic             neg
);
    localparam int HALF = XLEN / 2;

    logic [2*XLEN-1:0] src_flat;
    logic [2*XLEN-1:0] mag_flat;
    logic [1:0]        sbit;

    assign src_flat = {opb, opa};

    // One extension/magnitude unit per operand.
    for (genvar g = 0; g < 2; g++) begin : g_opnd
        logic [XLEN-1:0] src;
        logic [HALF-1:0] w;
        logic            s;
        logic [XLEN-1:0] m;

        assign src = src_flat[g*XLEN +: XLEN];
        assign w   = src[HALF-1:0];

        always_comb begin
            if (ctl.word) begin
                s = ctl.sgn & w[HALF-1];
                m = s ? {{HALF{1'b0}}, (~w + 1'b1)} : {{HALF{1'b0}}, w};
            end else begin
                s = ctl.sgn & src[XLEN-1];
                m = s ? (~src + 1'b1) : src;
            end
        end

        assign mag_flat[g*XLEN +: XLEN] = m;
        assign sbit[g] = s;
    end

    assign mag_a = mag_flat[XLEN-1:0];
    assign mag_b = mag_flat[2*XLEN-1:XLEN];
    assign neg   = sbit[0] ^ sbit[1];

endmodule

// File: rtl/mulx_step.sv
module mulx_step #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0] hi,
    input  logic [XLEN-1:0] lo,
    input  logic [XLEN-1:0] mcand,
    output logic [XLEN-1:0] hi_n,
    output logic [XLEN-1:0] lo_n
);
    logic [XLEN:0] sum;

    // Conditional add of the multiplicand, then one right shift of {carry,hi,lo}.
    always_comb begin
        sum  = {1'b0, hi} + {1'b0, (lo[0] ? mcand : {XLEN{1'b0}})};
        hi_n = sum[XLEN:1];
        lo_n = {sum[0], lo[XLEN-1:1]};
    end

endmodule

// File: rtl/mulx_fmt.sv
module mulx_fmt #(
    parameter int XLEN = 64
) (
    input  logic [XLEN-1:0]  hi,
    input  logic [XLEN-1:0]  lo,
    input  mulx_pkg::mctl_t  ctl,
    input  logic             neg,
    output logic [XLEN-1:0]  res
);
    import mulx_pkg::*;

    localparam int HALF = XLEN / 2;
    localparam int PW   = 2 * XLEN;

    logic [PW-1:0] mag;
    logic [PW-1:0] prod;

    always_comb begin
        // Word forms stop after HALF steps, leaving the product shifted up by HALF.
        if (ctl.word) begin
            mag = {{XLEN{1'b0}}, hi[HALF-1:0], lo[XLEN-1:HALF]};
        end else begin
            mag = {hi, lo};
        end
        prod = neg ? (~mag + 1'b1) : mag;
        case (ctl.rsel)
            RSEL_LO_W:  res = {{HALF{prod[HALF-1]}}, prod[HALF-1:0]};
            RSEL_MID_W: res = {{HALF{prod[XLEN-1]}}, prod[XLEN-1:HALF]};
            RSEL_LO_D:  res = prod[XLEN-1:0];
            default:    res = prod[PW-1:XLEN];
        endcase
    end

endmodule

// File: rtl/mulx_unit.sv
module mulx_unit #(
    parameter int               XLEN      = 64,
    parameter int               OPC_W     = 17,
    parameter logic [OPC_W-1:0] CODE_BASE = 17'h38
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [OPC_W-1:0] func_code,
    input  logic [XLEN-1:0]  src_a,
    input  logic [XLEN-1:0]  src_b,
    output logic             busy,
    output logic             done,
    output logic [XLEN-1:0]  result
);
    import mulx_pkg::*;

    localparam int HALF  = XLEN / 2;
    localparam int CNT_W = $clog2(XLEN);

    typedef struct packed {
        st_e              st;
        mctl_t            ctl;
        logic             neg;
        logic [XLEN-1:0]  mcand;
        logic [XLEN-1:0]  hi;
        logic [XLEN-1:0]  lo;
        logic [CNT_W-1:0] cnt;
        logic             done;
        logic [XLEN-1:0]  res;
    } state_t;

    state_t          q, d;
    mctl_t           dec;
    logic            code_ok;
    logic [XLEN-1:0] mag_a, mag_b;
    logic            prep_neg;
    logic [XLEN-1:0] step_hi, step_lo;
    logic [XLEN-1:0] fmt_res;

    assign code_ok = (func_code[OPC_W-1:3] == CODE_BASE[OPC_W-1:3]);
    assign dec     = decode_op(func_code[2:0]);

    mulx_opprep #(.XLEN(XLEN)) u_prep (
        .opa   (src_a),
        .opb   (src_b),
        .ctl   (dec),
        .mag_a (mag_a),
        .mag_b (mag_b),
        .neg   (prep_neg)
    );

    mulx_step #(.XLEN(XLEN)) u_step (
        .hi    (q.hi),
        .lo    (q.lo),
        .mcand (q.mcand),
        .hi_n  (step_hi),
        .lo_n  (step_lo)
    );

    mulx_fmt #(.XLEN(XLEN)) u_fmt (
        .hi  (q.hi),
        .lo  (q.lo),
        .ctl (q.ctl),
        .neg (q.neg),
        .res (fmt_res)
    );

    always_comb begin
        d      = q;
        d.done = 1'b0;
        case (q.st)
            ST_IDLE: begin
                if (start && code_ok) begin
                    d.st    = ST_RUN;
                    d.ctl   = dec;
                    d.neg   = prep_neg;
                    d.mcand = mag_a;
                    d.lo    = mag_b;
                    d.hi    = '0;
                    d.cnt   = dec.word ? CNT_W'(HALF - 1) : CNT_W'(XLEN - 1);
                end
            end
            ST_RUN: begin
                d.hi = step_hi;
                d.lo = step_lo;
                if (q.cnt == '0) begin
                    d.st = ST_FIN;
                end else begin
                    d.cnt = q.cnt - 1'b1;
                end
            end
            ST_FIN: begin
                d.res  = fmt_res;
                d.done = 1'b1;
                d.st   = ST_IDLE;
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{st: ST_IDLE, ctl: '0, neg: 1'b0, mcand: '0, hi: '0, lo: '0,
                   cnt: '0, done: 1'b0, res: '0};
        end else begin
            q <= d;
        end
    end

    assign busy   = (q.st != ST_IDLE);
    assign done   = q.done;
    assign result = q.res;

endmodule

// File: rtl/mulx_unit_chk.sv
module mulx_unit_chk #(
    parameter int               XLEN      = 64,
    parameter int               OPC_W     = 17,
    parameter logic [OPC_W-1:0] CODE_BASE = 17'h38
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [OPC_W-1:0] func_code,
    input logic             busy,
    input logic             done,
    input logic [XLEN-1:0]  result
);
    logic valid_code;
    assign valid_code = (func_code[OPC_W-1:3] == CODE_BASE[OPC_W-1:3]);

    a_r10_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!busy && !done && result == '0));

    a_r9_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    a_r9_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> $stable(result));

    a_r7_idle_at_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    a_r7_go_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && valid_code) |=> busy);

    a_r7_busy_until_done: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    a_r8_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));

    a_r6_bad_code_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && start && !valid_code) |=> !busy);

endmodule

bind mulx_unit mulx_unit_chk #(
    .XLEN      (XLEN),
    .OPC_W     (OPC_W),
    .CODE_BASE (CODE_BASE)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .func_code (func_code),
    .busy      (busy),
    .done      (done),
    .result    (result)
);

// File: tb/mulx_unit_tb.sv
`timescale 1ns/1ps
module mulx_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [16:0] func_code = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic        busy;
    logic        done;
    logic [63:0] result;

    int errors = 0;
    int checks = 0;
    int done_cnt = 0;

    always #2.5 clk = ~clk;

    mulx_unit u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .func_code (func_code),
        .src_a     (src_a),
        .src_b     (src_b),
        .busy      (busy),
        .done      (done),
        .result    (result)
    );

    always @(negedge clk) if (done) done_cnt++;

    localparam int NV = 16;
    localparam int TOP [NV] = '{0, 0, 1, 1, 2, 2, 3, 3, 4, 4, 4, 5, 5, 6, 7, 6};
    localparam logic [63:0] TA [NV] = '{
        64'h1234_5678_7FFF_FFFF, 64'h0000_0000_8000_0000,
        64'hFFFF_FFFF_8000_0000, 64'h0000_0000_0001_2345,
        64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0001_0000,
        64'h0123_4567_89AB_CDEF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
        64'h7FFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0123_4567_89AB_CDEF, 64'h5555_5555_8000_0000,
        64'h0000_0000_FFFF_FFFF, 64'h0000_0000_0000_0000};
    localparam logic [63:0] TB [NV] = '{
        64'hDEAD_0000_0000_0002, 64'h0000_0000_FFFF_FFFF,
        64'h0000_0000_8000_0000, 64'hFFFF_FFFF_FFFF_FFF0,
        64'hAAAA_AAAA_FFFF_FFFF, 64'h0000_0000_0001_0000,
        64'hFEDC_BA98_7654_3210, 64'h0000_0000_0000_0007,
        64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001,
        64'hFFFF_FFFF_FFFF_FFFE, 64'hFFFF_FFFF_FFFF_FFFF,
        64'h0000_0001_0000_0000, 64'h0000_0000_7FFF_FFFF,
        64'h1111_1111_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF};

    function automatic string req_of(input int op);
        case (op)
            0:       return "R1";
            1, 2:    return "R2";
            3:       return "R3";
            4, 5:    return "R4";
            default: return "R5";
        endcase
    endfunction

    function automatic bit is_word(input int op);
        return !(op == 3 || op == 4 || op == 5);
    endfunction

    // Reference: wide multiplies of explicitly extended operands.
    function automatic logic [63:0] ref_result(input int op, input logic [63:0] a, b);
        logic [127:0] sw, uw, sd, ud;
        sw = {{96{a[31]}}, a[31:0]} * {{96{b[31]}}, b[31:0]};
        uw = {96'b0, a[31:0]} * {96'b0, b[31:0]};
        sd = {{64{a[63]}}, a} * {{64{b[63]}}, b};
        ud = {64'b0, a} * {64'b0, b};
        case (op)
            0:       return {{32{sw[31]}}, sw[31:0]};
            1:       return {{32{sw[63]}}, sw[63:32]};
            2:       return {{32{uw[63]}}, uw[63:32]};
            3:       return ud[63:0];
            4:       return sd[127:64];
            5:       return ud[127:64];
            6:       return sw[63:0];
            default: return uw[63:0];
        endcase
    endfunction

    task automatic check64(input string req, input logic [63:0] got, exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic run_op(input logic [16:0] code, input logic [63:0] a, b,
                          output logic [63:0] res, output int lat);
        @(negedge clk);
        func_code = code; src_a = a; src_b = b; start = 1'b1;
        @(posedge clk);
        #1 start = 1'b0;
        check64("R7 busy after start", {63'b0, busy}, 64'd1);
        lat = 0;
        do begin
            @(posedge clk);
            #1;
            lat++;
        end while (!done && lat < 300);
        res = result;
    endtask

    task automatic do_op(input int op, input logic [63:0] a, b, input logic [63:0] exp);
        logic [63:0] r;
        int lat;
        run_op(17'h38 + 17'(op), a, b, r, lat);
        check64(req_of(op), r, exp);
        check64("R7 latency", 64'(lat), is_word(op) ? 64'd33 : 64'd65);
    endtask

    initial begin
        #(5ns * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [63:0] r, held;
        int lat, dc;

        // R10 reset state
        #12;
        check64("R10 busy in reset", {63'b0, busy}, 64'd0);
        check64("R10 done in reset", {63'b0, done}, 64'd0);
        check64("R10 result in reset", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Table of vectors, expected from reference model
        for (int i = 0; i < NV; i++) begin
            do_op(TOP[i], TA[i], TB[i], ref_result(TOP[i], TA[i], TB[i]));
        end

        // Directed corner cases with literal expectations
        do_op(0, 64'h0000_0000_7FFF_FFFF, 64'h2, 64'hFFFF_FFFF_FFFF_FFFE);      // R1
        do_op(2, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFE);        // R2
        do_op(4, 64'h8000_0000_0000_0000, 64'h8000_0000_0000_0000,
              64'h4000_0000_0000_0000);                                          // R4
        do_op(5, 64'hFFFF_FFFF_FFFF_FFFF, 64'h2, 64'h1);                         // R4
        do_op(7, 64'hFFFF_FFFF, 64'hFFFF_FFFF, 64'hFFFF_FFFE_0000_0001);        // R5
        do_op(6, 64'h8000_0000, 64'hFFFF_FFFF, 64'h0000_0000_8000_0000);        // R5
        do_op(3, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1);      // R3

        // R9: done lasts one cycle, result holds afterwards
        held = result;
        @(posedge clk); #1;
        check64("R9 done one cycle", {63'b0, done}, 64'd0);
        repeat (10) @(posedge clk);
        #1;
        check64("R9 result hold", result, held);

        // R8: start while busy ignored
        dc = done_cnt;
        @(negedge clk);
        func_code = 17'h3B; src_a = 64'd3; src_b = 64'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (3) @(negedge clk);
        func_code = 17'h38; src_a = 64'd7; src_b = 64'd7; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        lat = 0;
        while (!done && lat < 300) begin @(posedge clk); #1; lat++; end
        check64("R8 first result kept", result, 64'd15);
        repeat (80) @(posedge clk);
        #1;
        check64("R8 single done", 64'(done_cnt - dc), 64'd1);
        check64("R8 result after ignore", result, 64'd15);

        // R6: codes outside the range are ignored
        held = result;
        dc = done_cnt;
        @(negedge clk);
        func_code = 17'h37; src_a = 64'd9; src_b = 64'd9; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        check64("R6 code 0x37 idle", {63'b0, busy}, 64'd0);
        @(negedge clk);
        func_code = 17'h40; start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
        check64("R6 code 0x40 idle", {63'b0, busy}, 64'd0);
        repeat (70) @(posedge clk);
        #1;
        check64("R6 no done", 64'(done_cnt - dc), 64'd0);
        check64("R6 result unchanged", result, held);

        // R10: reset in the middle of an operation
        @(negedge clk);
        func_code = 17'h3C; src_a = 64'd11; src_b = 64'd13; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        #1;
        check64("R10 busy cleared", {63'b0, busy}, 64'd0);
        check64("R10 result cleared", result, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        dc = done_cnt;
        repeat (80) @(posedge clk);
        #1;
        check64("R10 abandoned op", 64'(done_cnt - dc), 64'd0);

        // Post-reset operation still works
        do_op(1, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF, 64'd0);    // R2

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule